// File: doc/BRIEF.md
# ECC Error-Marking Check Unit

This unit sits in a memory or cache data path and checks each 64-bit doubleword against its 8 check bits. The code is an odd-weight-column SEC-DED code. A single-bit error in either the data or the check bits is corrected. An uncorrectable word is sorted into one of two kinds. A word that has already been marked is recognised by one reserved syndrome value, and it passes through unchanged without a new report. Any other uncorrectable word is a fresh fault: the unit overwrites the word with a fixed marking pattern that holds its own 14-bit source identifier. It also writes check bits that make every later checker see the reserved syndrome. A single report pulse goes out for that word.

A fault is therefore reported once, at the first unit that sees it. Every unit further along the path sees a marked word and stays silent. There is one register stage between the input stream and the output stream.

Top module: `ecc_mark_chk`

## Requirements
- R1: While reset is asserted, and after its release, out_valid_o, raw_ue_report_o, marked_ue_seen_o and ce_corrected_o are 0 until the first valid beat has passed through.
- R2: out_valid_o equals in_valid_i delayed by one clock. The result for a beat appears in the cycle after the beat is accepted, and the mark ID sampled is the value present with the beat.
- R3: Code definition. The syndrome is the check bits generated from the received data, XORed with the received check bits. Check bit j contributes only to syndrome bit j. Data bit i has the i-th 8-bit column, counting upward in numeric order first through all values of weight 3 and then through values of weight 5, until 64 columns are taken.
- R4: A zero syndrome passes data and check bits unchanged, and all three flags stay 0.
- R5: A syndrome equal to the column of data bit i flips data bit i. The received check bits are passed on, ce_corrected_o is 1 and the other flags are 0.
- R6: A syndrome with exactly one bit set (bit j) keeps the data and corrects check bit j. ce_corrected_o is 1 and the other flags are 0.
- R7: A syndrome of exactly 0x7F marks an already-marked word. Data and check bits pass unchanged, marked_ue_seen_o is 1, raw_ue_report_o is 0 and ce_corrected_o is 0.
- R8: Any other nonzero syndrome is a raw uncorrectable error. The output data has bit 63 = 1, bits 62:56 = 0, bits 55:42 = the mark ID and bits 41:0 = 0. raw_ue_report_o is 1 and the other flags are 0.
- R9: The check bits for a raw uncorrectable error are the correct check bits of the marking data XOR 0x7F, so the marked word re-checks to syndrome 0x7F and is classed under R7.
- R10: raw_ue_report_o is high for exactly one cycle per raw beat. At most one of the three flags is high in any cycle, and a flag is only high together with out_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mark_id_i | input | 14 | Source identifier written into marked words |
| in_valid_i | input | 1 | Input beat valid |
| in_data_i | input | 64 | Input doubleword |
| in_ecc_i | input | 8 | Input check bits |
| out_valid_o | output | 1 | Output beat valid |
| out_data_o | output | 64 | Corrected, passed or marked doubleword |
| out_ecc_o | output | 8 | Output check bits |
| raw_ue_report_o | output | 1 | Pulse: a fresh uncorrectable error was marked |
| marked_ue_seen_o | output | 1 | Beat carried an already-marked word |
| ce_corrected_o | output | 1 | Beat had a single-bit error that was corrected |

## Verification
Two functions meet when a raw-error beat and a marked beat arrive on consecutive cycles. In that case the report pulse of the first beat and the marked flag of the second sit in adjacent output cycles. The bench provokes this by feeding the unit's own marked output straight back into its input on the next beat. It then expects the report to be high only for the first beat and marked_ue_seen_o only for the second. A back-to-back stream that mixes a raw error, a clean word and a correctable word is also judged beat by beat, so that no flag carries over into the following cycle.

// File: rtl/ecc_mark_pkg.sv
package ecc_mark_pkg;
  localparam int DATA_W = 64;
  localparam int ECC_W  = 8;
  localparam int ID_W   = 14;
  localparam int ID_LSB = 42;
  localparam int ZERO_LSB = ID_LSB + ID_W;
  localparam logic [ECC_W-1:0] MARK_SYN = 8'h7F;

  typedef enum logic [1:0] {CLS_CLEAN, CLS_CE, CLS_MUE, CLS_RUE} cls_e;

  typedef logic [DATA_W-1:0][ECC_W-1:0] col_tab_t;
  typedef logic [ECC_W-1:0][DATA_W-1:0] row_tab_t;

  function automatic int popcnt(input int v);
    int c;
    c = 0;
    for (int b = 0; b < ECC_W; b++) c += (v >> b) & 1;
    return c;
  endfunction

  // weight-3 columns ascending, then weight-5 columns ascending
  function automatic col_tab_t gen_cols();
    col_tab_t t;
    int n;
    t = '0;
    n = 0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 0; v < (1 << ECC_W); v++)
        if (popcnt(v) == w && n < DATA_W) begin
          t[n] = v[ECC_W-1:0];
          n++;
        end
    return t;
  endfunction

  localparam col_tab_t H_COLS = gen_cols();

  function automatic row_tab_t gen_rows();
    row_tab_t r;
    for (int j = 0; j < ECC_W; j++)
      for (int i = 0; i < DATA_W; i++)
        r[j][i] = H_COLS[i][j];
    return r;
  endfunction

  localparam row_tab_t H_ROWS = gen_rows();
endpackage

// File: rtl/ecc_mark_enc.sv
module ecc_mark_enc
  import ecc_mark_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [ECC_W-1:0]  ecc_o
);
  for (genvar j = 0; j < ECC_W; j++) begin : g_row
    assign ecc_o[j] = ^(data_i & H_ROWS[j]);
  end
endmodule

// File: rtl/ecc_mark_dec.sv
module ecc_mark_dec
  import ecc_mark_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [ECC_W-1:0]  ecc_i,
  output cls_e              cls_o,
  output logic [DATA_W-1:0] data_o,
  output logic [ECC_W-1:0]  ecc_o
);
  logic [ECC_W-1:0]  gen_ecc;
  logic [ECC_W-1:0]  syn;
  logic [DATA_W-1:0] data_hit;
  logic              chk_hit;

  ecc_mark_enc u_enc (.data_i(data_i), .ecc_o(gen_ecc));

  assign syn = gen_ecc ^ ecc_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    assign data_hit[i] = (syn == H_COLS[i]);
  end

  assign chk_hit = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

  always_comb begin
    if (syn == '0)                  cls_o = CLS_CLEAN;
    else if (syn == MARK_SYN)       cls_o = CLS_MUE;
    else if (chk_hit || |data_hit)  cls_o = CLS_CE;
    else                            cls_o = CLS_RUE;
  end

  // received check bits already match the corrected data on a data-bit fix
  assign data_o = data_i ^ data_hit;
  assign ecc_o  = chk_hit ? (ecc_i ^ syn) : ecc_i;
endmodule

// File: rtl/ecc_mark_fmt.sv
module ecc_mark_fmt
  import ecc_mark_pkg::*;
(
  input  logic [ID_W-1:0]   mark_id_i,
  output logic [DATA_W-1:0] data_o,
  output logic [ECC_W-1:0]  ecc_o
);
  logic [ECC_W-1:0] good_ecc;

  always_comb begin
    data_o = '0;
    data_o[DATA_W-1] = 1'b1;
    data_o[ZERO_LSB-1:ID_LSB] = mark_id_i;
  end

  ecc_mark_enc u_enc (.data_i(data_o), .ecc_o(good_ecc));

  assign ecc_o = good_ecc ^ MARK_SYN;
endmodule

// File: rtl/ecc_mark_chk.sv
module ecc_mark_chk
  import ecc_mark_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   mark_id_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [ECC_W-1:0]  in_ecc_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [ECC_W-1:0]  out_ecc_o,
  output logic              raw_ue_report_o,
  output logic              marked_ue_seen_o,
  output logic              ce_corrected_o
);
  cls_e              cls;
  logic [DATA_W-1:0] dec_data, mrk_data, nxt_data;
  logic [ECC_W-1:0]  dec_ecc, mrk_ecc, nxt_ecc;

  ecc_mark_dec u_dec (
    .data_i(in_data_i), .ecc_i(in_ecc_i),
    .cls_o(cls), .data_o(dec_data), .ecc_o(dec_ecc)
  );

  ecc_mark_fmt u_fmt (
    .mark_id_i(mark_id_i), .data_o(mrk_data), .ecc_o(mrk_ecc)
  );

  always_comb begin
    if (cls == CLS_RUE) begin
      nxt_data = mrk_data;
      nxt_ecc  = mrk_ecc;
    end else begin
      nxt_data = dec_data;
      nxt_ecc  = dec_ecc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o      <= 1'b0;
      raw_ue_report_o  <= 1'b0;
      marked_ue_seen_o <= 1'b0;
      ce_corrected_o   <= 1'b0;
    end else begin
      out_valid_o      <= in_valid_i;
      raw_ue_report_o  <= in_valid_i && (cls == CLS_RUE);
      marked_ue_seen_o <= in_valid_i && (cls == CLS_MUE);
      ce_corrected_o   <= in_valid_i && (cls == CLS_CE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_data_o <= '0;
      out_ecc_o  <= '0;
    end else if (in_valid_i) begin
      out_data_o <= nxt_data;
      out_ecc_o  <= nxt_ecc;
    end
  end
endmodule

// File: rtl/ecc_mark_chk_sva.sv
module ecc_mark_chk_sva
  import ecc_mark_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ID_W-1:0]   mark_id_i,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic [ECC_W-1:0]  in_ecc_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic [ECC_W-1:0]  out_ecc_o,
  input logic              raw_ue_report_o,
  input logic              marked_ue_seen_o,
  input logic              ce_corrected_o
);
  p_valid_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_idle_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_flags_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({raw_ue_report_o, marked_ue_seen_o, ce_corrected_o}));
  p_flags_need_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_ue_report_o || marked_ue_seen_o || ce_corrected_o) |-> out_valid_o);
  p_mark_layout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (raw_ue_report_o |->
      (out_data_o[DATA_W-1] && out_data_o[DATA_W-2:ZERO_LSB] == '0 &&
       out_data_o[ZERO_LSB-1:ID_LSB] == $past(mark_id_i) &&
       out_data_o[ID_LSB-1:0] == '0)));
  p_marked_passthru_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (marked_ue_seen_o |->
      (out_data_o == $past(in_data_i) && out_ecc_o == $past(in_ecc_i))));
endmodule

bind ecc_mark_chk ecc_mark_chk_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .mark_id_i(mark_id_i),
  .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ecc_i(in_ecc_i),
  .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ecc_o(out_ecc_o),
  .raw_ue_report_o(raw_ue_report_o), .marked_ue_seen_o(marked_ue_seen_o),
  .ce_corrected_o(ce_corrected_o)
);

// File: tb/tb_ecc_mark_chk.sv
module tb_ecc_mark_chk;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] mark_id_i = '0;
  logic        in_valid_i = 1'b0;
  logic [63:0] in_data_i = '0;
  logic [7:0]  in_ecc_i = '0;
  logic        out_valid_o;
  logic [63:0] out_data_o;
  logic [7:0]  out_ecc_o;
  logic        raw_ue_report_o, marked_ue_seen_o, ce_corrected_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] col [64];

  always #2.5 clk_i = ~clk_i;

  ecc_mark_chk dut (.*);

  function automatic logic [7:0] benc(input logic [63:0] d);
    logic [7:0] e;
    e = '0;
    for (int i = 0; i < 64; i++) if (d[i]) e ^= col[i];
    return e;
  endfunction

  function automatic logic [63:0] mark_word(input logic [13:0] id);
    return {1'b1, 7'd0, id, 42'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // flags packed as {valid, raw, marked, ce}
  task automatic expect_out(input string req, input logic [63:0] d, input logic [7:0] e, input logic [3:0] f);
    logic [3:0] af;
    af = {out_valid_o, raw_ue_report_o, marked_ue_seen_o, ce_corrected_o};
    chk(out_data_o == d && out_ecc_o == e && af == f, req,
        {af, 4'h0, out_ecc_o, out_data_o}, {f, 4'h0, e, d});
  endtask

  // drive one beat at a negedge, observe at the following negedge
  task automatic beat(input logic [63:0] d, input logic [7:0] e);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = d; in_ecc_i = e;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  initial begin
    int n;
    n = 0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 0; v < 256; v++)
        if ($countones(8'(v)) == w && n < 64) begin col[n] = 8'(v); n++; end
  end

  initial begin
    logic [63:0] d, md, cap_d;
    logic [7:0]  e, me, cap_e;
    #1;
    @(negedge clk_i);
    chk({out_valid_o, raw_ue_report_o, marked_ue_seen_o, ce_corrected_o} == 4'b0,
        "R1 in reset", 80'(out_valid_o), 80'(0));
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({out_valid_o, raw_ue_report_o, marked_ue_seen_o, ce_corrected_o} == 4'b0,
        "R1 after release", 80'(out_valid_o), 80'(0));

    // R4 clean words
    for (int k = 0; k < 8; k++) begin
      d = {$urandom, $urandom};
      if (k == 0) d = '0;
      if (k == 1) d = '1;
      e = benc(d);
      beat(d, e);
      expect_out("R4 clean", d, e, 4'b1000);
    end

    // R5 each data bit flipped; R3 column order
    mark_id_i = 14'h1234;
    for (int i = 0; i < 64; i++) begin
      d = {$urandom, $urandom};
      e = benc(d);
      beat(d ^ (64'd1 << i), e);
      expect_out("R5/R3 data bit", d, e, 4'b1001);
    end

    // R6 each check bit flipped
    for (int j = 0; j < 8; j++) begin
      d = {$urandom, $urandom};
      e = benc(d);
      beat(d, e ^ (8'd1 << j));
      expect_out("R6 check bit", d, e, 4'b1001);
    end

    // R8/R9 double errors over pairs of positions in the 72-bit word
    for (int i = 0; i < 72; i++) begin
      int j;
      logic [71:0] cw;
      j = (i * 7 + 5) % 72;
      if (j == i) j = (i + 1) % 72;
      mark_id_i = 14'(i * 229 + 3);
      d = {$urandom, $urandom};
      cw = {benc(d), d} ^ (72'd1 << i) ^ (72'd1 << j);
      beat(cw[63:0], cw[71:64]);
      md = mark_word(mark_id_i);
      me = benc(md) ^ 8'h7F;
      expect_out("R8/R9 raw UE", md, me, 4'b1100);
      chk((benc(out_data_o) ^ out_ecc_o) == 8'h7F, "R9 resyndrome",
          80'(benc(out_data_o) ^ out_ecc_o), 80'h7F);
    end

    // R7 already-marked words with several IDs and arbitrary data
    for (int k = 0; k < 6; k++) begin
      d = (k < 3) ? mark_word(14'(k * 4099)) : {$urandom, $urandom};
      e = benc(d) ^ 8'h7F;
      beat(d, e);
      expect_out("R7 marked passthru", d, e, 4'b1010);
    end

    // R7/R10 loopback: raw beat then own output fed back next cycle
    mark_id_i = 14'h2ABC;
    d = 64'hDEAD_BEEF_0123_4567;
    e = benc(d) ^ 8'h03;
    @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = d; in_ecc_i = e;
    @(negedge clk_i);
    cap_d = out_data_o; cap_e = out_ecc_o;
    expect_out("R10 loop raw", mark_word(14'h2ABC), benc(mark_word(14'h2ABC)) ^ 8'h7F, 4'b1100);
    mark_id_i = 14'h0555;
    in_data_i = cap_d; in_ecc_i = cap_e;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    expect_out("R7/R10 loop marked", cap_d, cap_e, 4'b1010);
    @(negedge clk_i);
    chk({out_valid_o, raw_ue_report_o, marked_ue_seen_o, ce_corrected_o} == 4'b0,
        "R2/R10 idle after stream", 80'({out_valid_o, raw_ue_report_o}), 80'(0));

    // R2/R10 back-to-back mixed stream: raw, clean, correctable
    mark_id_i = 14'h0F0F;
    @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = 64'h1; in_ecc_i = benc(64'h1) ^ 8'h81;
    @(negedge clk_i);
    expect_out("R10 stream raw", mark_word(14'h0F0F), benc(mark_word(14'h0F0F)) ^ 8'h7F, 4'b1100);
    mark_id_i = 14'h3FFF;
    in_data_i = 64'h55; in_ecc_i = benc(64'h55);
    @(negedge clk_i);
    expect_out("R10 stream clean", 64'h55, benc(64'h55), 4'b1000);
    in_data_i = 64'h55 ^ (64'd1 << 40); in_ecc_i = benc(64'h55);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    expect_out("R10 stream ce", 64'h55, benc(64'h55), 4'b1001);
    @(negedge clk_i);
    chk(out_valid_o == 1'b0 && ce_corrected_o == 1'b0, "R2 valid drops",
        80'({out_valid_o, ce_corrected_o}), 80'(0));

    // R1 reset mid-run clears outputs
    @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = '0; in_ecc_i = 8'h11;
    #1 rst_ni = 1'b0;
    @(negedge clk_i);
    chk({out_valid_o, raw_ue_report_o, marked_ue_seen_o, ce_corrected_o} == 4'b0,
        "R1 reset mid-run", 80'(out_valid_o), 80'(0));
    in_valid_i = 1'b0;

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule